// File: doc/BRIEF.md
# Data Cache Tag and Status Store with Parity Fault Injection

This block holds the tag and status bits of a small four-way set-associative data cache. Each line keeps a valid bit, a tag, four dirty bits (one for each 8-byte quarter of a 32-byte line) and one parity bit beside each dirty bit. The cache pipeline presents one request per cycle: a load lookup, a store, a zero-line operation, a touch (prefetch) or a line fill. One cycle later the block returns hit or miss, the way that hit, a multi-hit flag and a dirty-parity error flag. Data storage, the bus side and interrupt delivery belong to other blocks.

Four configuration inputs support fault-injection tests. One makes every dirty-parity bit written from then on wrong. One widens that corruption to all four parity bits of the written line. One makes touches miss, so a second copy of a resident line can be placed in the same set. One globally enables touch allocation. Used together, these let software create a parity error or a multi-hit condition on purpose and check its error handling.

Top module: `dcache_tag_status`

## Requirements
- R1: Each cycle with `req_valid` high produces `rsp_valid` high on the next cycle. A cycle without a request produces `rsp_valid` low on the next cycle, with `rsp_hit`, `rsp_way`, `rsp_multi_hit` and `rsp_parity_err` all low.
- R2: The address splits into tag `req_addr[28:9]`, set index `req_addr[8:5]` and quarter `req_addr[4:3]`. `rsp_hit` is high when a valid way of the indexed set holds the tag. `rsp_way` gives the lowest such way, or 0 on a miss.
- R3: With injection off, a store (`req_op`=1) that hits with `req_wt` low sets the dirty bit of the addressed quarter. Every parity bit written equals its dirty bit, so later lookups of that line report no parity error.
- R4: `rsp_parity_err` pulses with the response when any valid way matching the request has a dirty bit that differs from its parity bit. It also pulses when an allocation overwrites a valid victim line with such a mismatch.
- R5: While `cfg_inject` is high, each parity bit written is the inverse of its dirty bit. A store corrupts only the parity of the quarter it addresses.
- R6: While `cfg_inject` and `cfg_all` are both high, any write to a line's status sets all four parity bits to the inverse of the new dirty bits.
- R7: A store hit with `req_wt` high changes neither dirty nor parity bits, whatever the injection controls are.
- R8: `rsp_multi_hit` pulses when more than one valid way of the indexed set matches the request tag.
- R9: A touch (`req_op`=3) while `cfg_touch_en` is low changes no state.
- R10: With `cfg_touch_en` high, a touch that misses allocates a line. A touch that hits does nothing unless `cfg_force_miss` is high, in which case it allocates a further copy into a way that does not already match.
- R11: A fill (`req_op`=4) or zero-line (`req_op`=2) that misses allocates a line. The victim is the first non-matching way found by searching upward, with wrap-around, from the set's round-robin pointer, and the pointer then moves to the way after the victim. A fill leaves all four dirty bits clear. A zero-line sets all four, on a hit or on allocation.
- R12: A load (`req_op`=0) never changes state. A store that misses allocates nothing.
- R13: Synchronous reset `rst` clears every valid bit, dirty bit, parity bit and round-robin pointer, and forces all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 load, 1 store, 2 zero-line, 3 touch, 4 fill |
| req_addr | input | 29 | Byte address: tag, set, quarter |
| req_wt | input | 1 | Store targets a write-through page |
| cfg_inject | input | 1 | Write wrong dirty parity |
| cfg_all | input | 1 | Corrupt all four parity bits of a written line |
| cfg_force_miss | input | 1 | Touches treat hits as misses |
| cfg_touch_en | input | 1 | Global touch allocation enable |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Tag matched a valid way |
| rsp_way | output | 2 | Lowest matching way |
| rsp_multi_hit | output | 1 | More than one way matched |
| rsp_parity_err | output | 1 | Dirty/parity mismatch seen |

## Verification
A wrong valid bit or tag shows up as a wrong hit flag or way on the very next lookup of that set. A wrong victim choice or a drifted round-robin pointer shows up as a wrong way on a later hit, or as a line that is missing when it should still be resident. Dirty or parity bits written wrongly stay hidden until that line is looked up again or evicted, so the bench revisits every corrupted and every clean line with loads and fills. A behavioural model compares all five response outputs on every cycle, so any divergence is reported within one cycle of the lookup that exposes it.

// File: rtl/dcache_tag_status.sv
module dcache_tag_status #(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 20,
  parameter int LINE_B = 32,
  parameter int QTRS   = 4
) (
  input  logic                                                    clk,
  input  logic                                                    rst,
  input  logic                                                    req_valid,
  input  logic [2:0]                                              req_op,
  input  logic [TAG_W+$clog2(SETS)+$clog2(LINE_B)-1:0]            req_addr,
  input  logic                                                    req_wt,
  input  logic                                                    cfg_inject,
  input  logic                                                    cfg_all,
  input  logic                                                    cfg_force_miss,
  input  logic                                                    cfg_touch_en,
  output logic                                                    rsp_valid,
  output logic                                                    rsp_hit,
  output logic [$clog2(WAYS)-1:0]                                 rsp_way,
  output logic                                                    rsp_multi_hit,
  output logic                                                    rsp_parity_err
);
  localparam int IDX_W = $clog2(SETS);
  localparam int OFF_W = $clog2(LINE_B);
  localparam int WAY_W = $clog2(WAYS);
  localparam int Q_W   = $clog2(QTRS);

  localparam logic [2:0] OP_LOAD  = 3'd0;
  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_ZERO  = 3'd2;
  localparam logic [2:0] OP_TOUCH = 3'd3;
  localparam logic [2:0] OP_FILL  = 3'd4;

  logic [WAYS-1:0]  vld_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [QTRS-1:0]  dty_q [SETS][WAYS];
  logic [QTRS-1:0]  par_q [SETS][WAYS];
  logic [WAY_W-1:0] rr_q  [SETS];

  wire [IDX_W-1:0] idx = req_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] tg  = req_addr[OFF_W+IDX_W +: TAG_W];
  wire [Q_W-1:0]   qtr = req_addr[OFF_W-Q_W +: Q_W];

  wire is_ld    = req_op == OP_LOAD;
  wire is_st    = req_op == OP_STORE;
  wire is_zero  = req_op == OP_ZERO;
  wire is_touch = req_op == OP_TOUCH;
  wire is_fill  = req_op == OP_FILL;

  logic [WAYS-1:0]  match;
  logic [WAY_W-1:0] hway, vic, wr_way;
  logic             perr_m, vic_ok, alloc, upd, evict_perr;
  logic [QTRS-1:0]  wmask, nd, np;

  always_comb begin
    hway   = '0;
    perr_m = 1'b0;
    for (int w = WAYS-1; w >= 0; w--) begin
      match[w] = vld_q[idx][w] && (tag_q[idx][w] == tg);
      if (match[w]) begin
        hway = WAY_W'(w);
        if (dty_q[idx][w] != par_q[idx][w]) perr_m = 1'b1;
      end
    end
    vic    = '0;
    vic_ok = 1'b0;
    for (int k = WAYS-1; k >= 0; k--) begin
      if (!match[rr_q[idx] + WAY_W'(k)]) begin
        vic    = rr_q[idx] + WAY_W'(k);
        vic_ok = 1'b1;
      end
    end
  end

  wire hit = |match;

  assign alloc = req_valid && vic_ok &&
                 (((is_fill || is_zero) && !hit) ||
                  (is_touch && cfg_touch_en && (!hit || cfg_force_miss)));
  assign upd   = req_valid && !alloc && hit && ((is_st && !req_wt) || is_zero);
  assign wr_way = alloc ? vic : hway;
  assign evict_perr = alloc && vld_q[idx][vic] && (dty_q[idx][vic] != par_q[idx][vic]);

  always_comb begin
    if (alloc || is_zero) begin
      wmask = '1;
      nd    = is_zero ? '1 : '0;
    end else begin
      wmask = QTRS'(1) << qtr;
      nd    = dty_q[idx][wr_way] | wmask;
    end
    np = (par_q[idx][wr_way] & ~wmask) | ((nd ^ {QTRS{cfg_inject}}) & wmask);
    if (cfg_inject && cfg_all) np = ~nd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          dty_q[s][w] <= '0;
          par_q[s][w] <= '0;
        end
      end
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_way        <= '0;
      rsp_multi_hit  <= 1'b0;
      rsp_parity_err <= 1'b0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_hit        <= req_valid && hit;
      rsp_way        <= req_valid ? hway : '0;
      rsp_multi_hit  <= req_valid && ($countones(match) > 1);
      rsp_parity_err <= req_valid && (perr_m || evict_perr);
      if (alloc) begin
        vld_q[idx][vic] <= 1'b1;
        tag_q[idx][vic] <= tg;
        rr_q[idx]       <= vic + WAY_W'(1);
      end
      if (alloc || upd) begin
        dty_q[idx][wr_way] <= nd;
        par_q[idx][wr_way] <= np;
      end
    end
  end

  a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_hit && !rsp_multi_hit && !rsp_parity_err);
  a_r8_multi_needs_hit: assert property (@(posedge clk) disable iff (rst)
    rsp_multi_hit |-> rsp_hit && rsp_valid);
  a_r10_victim_not_matching: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !match[vic]);
  a_r12_load_readonly: assert property (@(posedge clk) disable iff (rst)
    (req_valid && is_ld) |-> !alloc && !upd);
  a_r9_touch_gated: assert property (@(posedge clk) disable iff (rst)
    (req_valid && is_touch && !cfg_touch_en) |-> !alloc && !upd);
  a_r7_wt_store_no_write: assert property (@(posedge clk) disable iff (rst)
    (req_valid && is_st && req_wt) |-> !alloc && !upd);
endmodule

// File: tb/test_dcache_tag_status.sv
module test_dcache_tag_status;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [28:0] req_addr = '0;
  logic req_wt = 1'b0;
  logic cfg_inject = 1'b0, cfg_all = 1'b0, cfg_force_miss = 1'b0, cfg_touch_en = 1'b0;
  logic rsp_valid, rsp_hit, rsp_multi_hit, rsp_parity_err;
  logic [1:0] rsp_way;

  always #(CLK_P/2) clk = ~clk;

  dcache_tag_status i_dcache_tag_status (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wt(req_wt), .cfg_inject(cfg_inject), .cfg_all(cfg_all),
    .cfg_force_miss(cfg_force_miss), .cfg_touch_en(cfg_touch_en),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_multi_hit(rsp_multi_hit), .rsp_parity_err(rsp_parity_err));

  bit       m_v   [16][4];
  int       m_tag [16][4];
  bit [3:0] m_d   [16][4];
  bit [3:0] m_p   [16][4];
  int       m_rr  [16];

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R13";
  bit done = 1'b0;

  function automatic int mk(int t, int s, int q);
    return (t << 9) | (s << 5) | (q << 3);
  endfunction

  task automatic chk(string fld, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, fld, act, exp);
    end
  endtask

  task automatic step(bit v, int op, int addr, bit wt);
    int e_v, e_h, e_w, e_m, e_p;
    req_valid = v; req_op = 3'(op); req_addr = 29'(addr); req_wt = wt;
    e_v = 0; e_h = 0; e_w = 0; e_m = 0; e_p = 0;
    if (rst) begin
      for (int s = 0; s < 16; s++) begin
        m_rr[s] = 0;
        for (int w = 0; w < 4; w++) begin m_v[s][w] = 0; m_d[s][w] = 0; m_p[s][w] = 0; end
      end
    end else if (v) begin
      int idx, tg, q, cnt, first, vic, ww;
      bit found, al, up;
      bit [3:0] mask, nd, np;
      idx = (addr >> 5) & 15; tg = (addr >> 9) & 20'hfffff; q = (addr >> 3) & 3;
      cnt = 0; first = -1; found = 0; vic = 0;
      for (int w = 0; w < 4; w++)
        if (m_v[idx][w] && m_tag[idx][w] == tg) begin
          cnt++;
          if (first < 0) first = w;
          if (m_d[idx][w] != m_p[idx][w]) e_p = 1;
        end
      for (int k = 0; k < 4; k++) begin
        int w = (m_rr[idx] + k) % 4;
        if (!found && !(m_v[idx][w] && m_tag[idx][w] == tg)) begin vic = w; found = 1; end
      end
      al = found && (((op == 4 || op == 2) && cnt == 0) ||
                     (op == 3 && cfg_touch_en && (cnt == 0 || cfg_force_miss)));
      up = !al && cnt > 0 && ((op == 1 && !wt) || op == 2);
      ww = 0; mask = 0; nd = 0;
      if (al) begin
        if (m_v[idx][vic] && m_d[idx][vic] != m_p[idx][vic]) e_p = 1;
        ww = vic; m_v[idx][vic] = 1; m_tag[idx][vic] = tg; m_rr[idx] = (vic + 1) % 4;
        mask = 4'hf; nd = (op == 2) ? 4'hf : 4'h0;
      end else if (up) begin
        ww = first;
        if (op == 2) begin mask = 4'hf; nd = 4'hf; end
        else begin mask = 4'(1 << q); nd = m_d[idx][ww] | mask; end
      end
      if (al || up) begin
        np = (m_p[idx][ww] & ~mask) | ((nd ^ (cfg_inject ? 4'hf : 4'h0)) & mask);
        if (cfg_inject && cfg_all) np = ~nd;
        m_d[idx][ww] = nd; m_p[idx][ww] = np;
      end
      e_v = 1; e_h = cnt > 0; e_w = (cnt > 0) ? first : 0; e_m = cnt > 1;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R1 rsp_valid", rsp_valid, e_v);
    chk("R2 rsp_hit", rsp_hit, e_h);
    chk("R2 rsp_way", rsp_way, e_w);
    chk("R8 rsp_multi_hit", rsp_multi_hit, e_m);
    chk("R4 rsp_parity_err", rsp_parity_err, e_p);
  endtask

  initial begin
    @(negedge clk);
    cur_req = "R13";
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    rst = 1'b0;
    step(0, 0, 0, 0);
    step(1, 0, mk(5, 1, 0), 0);
    cur_req = "R11";
    step(1, 4, mk(10, 1, 0), 0);
    step(1, 4, mk(11, 1, 0), 0);
    step(1, 4, mk(12, 1, 0), 0);
    step(1, 4, mk(13, 1, 0), 0);
    step(1, 4, mk(14, 1, 0), 0);
    cur_req = "R2";
    step(1, 0, mk(10, 1, 0), 0);
    step(1, 0, mk(13, 1, 2), 0);
    step(1, 0, mk(14, 1, 1), 0);
    cur_req = "R12";
    step(1, 1, mk(40, 2, 1), 0);
    step(1, 0, mk(40, 2, 1), 0);
    cur_req = "R3";
    step(1, 1, mk(11, 1, 2), 0);
    step(1, 0, mk(11, 1, 0), 0);
    cur_req = "R5";
    cfg_inject = 1;
    step(1, 1, mk(12, 1, 1), 0);
    cfg_inject = 0;
    step(1, 0, mk(12, 1, 0), 0);
    cur_req = "R4";
    step(1, 4, mk(20, 1, 0), 0);
    step(1, 4, mk(21, 1, 0), 0);
    step(1, 4, mk(22, 1, 0), 0);
    step(1, 0, mk(12, 1, 0), 0);
    cur_req = "R6";
    step(1, 2, mk(30, 3, 0), 0);
    cfg_inject = 1; cfg_all = 1;
    step(1, 1, mk(30, 3, 0), 0);
    cfg_inject = 0; cfg_all = 0;
    step(1, 1, mk(30, 3, 0), 0);
    step(1, 0, mk(30, 3, 0), 0);
    step(1, 4, mk(31, 4, 0), 0);
    cfg_inject = 1;
    step(1, 1, mk(31, 4, 0), 0);
    cfg_inject = 0;
    step(1, 1, mk(31, 4, 0), 0);
    step(1, 0, mk(31, 4, 0), 0);
    cur_req = "R7";
    step(1, 4, mk(32, 5, 0), 0);
    cfg_inject = 1; cfg_all = 1;
    step(1, 1, mk(32, 5, 3), 1);
    cfg_inject = 0; cfg_all = 0;
    step(1, 0, mk(32, 5, 3), 0);
    cur_req = "R9";
    step(1, 3, mk(50, 6, 0), 0);
    step(1, 0, mk(50, 6, 0), 0);
    cur_req = "R10";
    cfg_touch_en = 1;
    step(1, 3, mk(50, 6, 0), 0);
    step(1, 3, mk(50, 6, 0), 0);
    step(1, 0, mk(50, 6, 0), 0);
    cfg_force_miss = 1;
    step(1, 3, mk(50, 6, 0), 0);
    cfg_force_miss = 0;
    cur_req = "R8";
    step(1, 0, mk(50, 6, 0), 0);
    step(1, 2, mk(50, 6, 0), 0);
    cur_req = "R11";
    step(1, 2, mk(60, 7, 0), 0);
    step(1, 0, mk(60, 7, 0), 0);
    cur_req = "R1";
    step(0, 0, mk(50, 6, 0), 0);
    cur_req = "R10";
    for (int i = 0; i < 400; i++) begin
      int t, s, op;
      t = 1 + $urandom_range(0, 3); s = $urandom_range(8, 9); op = $urandom_range(0, 4);
      cfg_inject = ($urandom_range(0, 7) == 0);
      cfg_all = $urandom_range(0, 1);
      cfg_force_miss = ($urandom_range(0, 3) == 0);
      cfg_touch_en = $urandom_range(0, 1);
      step($urandom_range(0, 7) != 0, op, mk(t, s, $urandom_range(0, 3)), $urandom_range(0, 1) == 1);
    end
    cur_req = "R13";
    rst = 1;
    step(1, 0, mk(10, 1, 0), 0);
    rst = 0;
    step(1, 0, mk(10, 1, 0), 0);
    step(1, 0, mk(2, 8, 0), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule